// File: doc/BRIEF.md
# Bus hold requester with throttle timers

This block sits between an internal DMA engine and the local bus of a host processor. When the engine wants to move data, the block raises an active-high hold request toward the host. It brings the host's active-high grant through a two-stage synchronizer, and only once the synchronized grant is high does it tell the engine that it owns the bus. When the engine is done, or when the block is forced off the bus, it raises a yield indication to the engine. It keeps its request up until the engine's current bus cycle has finished, then drops the request. It never requests again until it has seen the synchronized grant go low.

Two programmable 16-bit limits bound bus usage. The on-time limit caps how long one tenure may last. The off-time limit sets how long the block must stay off the bus after the on-time limit has forced it off. Either limit set to zero is disabled. The on-time count can start either at the beginning of ownership (internal trigger) or at the first cycle of ownership in which an external bus-request input is high (external trigger). The host can also take the bus back at any time by lowering the grant. The block then yields and drops its request as soon as the running bus cycle has finished.

Top module: `bus_hold_requester`

## Requirements
- R1: While reset is low, and after reset until the engine asks for the bus, `hold_req`, `owns_bus` and `must_yield` are all 0.
- R2: The grant is used only after two synchronizer stages. With `hold_req` high, `owns_bus` rises at the third rising clock edge after `grant_async` is first sampled high.
- R3: From the idle state, `hold_req` goes high at the first rising edge at which `want_bus` is sampled high.
- R4: If `want_bus` is low during ownership, `must_yield` rises at the next edge. `hold_req` falls at the first edge where `cycle_busy` is low, while the grant is still high.
- R5: If the synchronized grant is low during ownership, `must_yield` rises at the next edge. `hold_req` falls at the first following edge at which `cycle_busy` is low.
- R6: After a release, `hold_req` stays low until the synchronized grant has been seen low, whatever `want_bus` does.
- R7: With internal trigger (`ext_mode`=0) and `on_limit`=N>0, `owns_bus` is high with `must_yield` low for exactly N cycles, after which `must_yield` rises.
- R8: `on_limit`=0 disables the on-time limit: ownership lasts while `want_bus` and the grant stay high.
- R9: With external trigger (`ext_mode`=1), no on-time expiry happens until `ext_trig` is high during ownership. The cycle in which `ext_trig` is first high counts as the first of the N cycles.
- R10: After a release forced by the on-time limit, the block waits `off_limit` extra cycles after the grant is seen low before it may request again. With `off_limit`=0 there is no extra wait.
- R11: `must_yield` is high only while `owns_bus` is high, and `owns_bus` is high only while `hold_req` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| want_bus | input | 1 | Engine wants bus mastership (level) |
| cycle_busy | input | 1 | Engine has a bus cycle in progress; release waits for it |
| grant_async | input | 1 | Host grant, active high, asynchronous |
| ext_trig | input | 1 | External bus-request input that starts the on-time count in external mode |
| ext_mode | input | 1 | 0: on-time count starts with ownership; 1: started by `ext_trig` |
| on_limit | input | 16 | Maximum tenure in cycles; 0 disables |
| off_limit | input | 16 | Mandatory off-time after an on-time release; 0 disables |
| hold_req | output | 1 | Bus request to the host, active high |
| owns_bus | output | 1 | Engine may run bus cycles |
| must_yield | output | 1 | Engine must finish its current cycle and start no new one |

## Verification
The checker watches several rules on every cycle: the ordering of the three outputs, that ownership starts only two sampled cycles after the grant, that a lost grant is followed by a yield, that the request drops once the cycle is no longer busy, that no tenure under the internal trigger runs past the on-time limit, and that a timed release keeps the request low for at least the off-time. The exact cycle counts are shown only by the bench's scenarios under a host model that follows the request. These cover external triggering, disabled limits, the refusal to request while the grant is stuck high, and the exact off-time gap, all compared each clock against a behavioural model.

// File: rtl/bht_pkg.sv
// Shared types for the bus hold requester.
package bht_pkg;
    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_REQ     = 3'd1,
        ST_OWN     = 3'd2,
        ST_YIELD   = 3'd3,
        ST_WAITLOW = 3'd4,
        ST_BACKOFF = 3'd5
    } bus_state_t;
endpackage

// File: rtl/grant_synchronizer.sv
// Multi-stage flip-flop synchronizer for the host grant.
// Assumes STAGES >= 1; output is the last stage, cleared by reset.
module grant_synchronizer #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] chain;

    genvar i;
    generate
        for (i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                // First stage samples the asynchronous input.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[0] <= 1'b0;
                    else        chain[0] <= async_in;
                end
            end else begin : g_next
                // Later stages shift the sampled value along.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[i] <= 1'b0;
                    else        chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/tenure_timer.sv
// Cycle counter that flags the last of `limit` counted cycles.
// Assumes limit is stable while counting; limit of zero never expires.
module tenure_timer #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          run,
    input  logic [CW-1:0] limit,
    output logic          expired
);
    logic [CW-1:0] cnt;
    logic [CW:0]   nxt;

    assign nxt     = {1'b0, cnt} + {{CW{1'b0}}, 1'b1};
    assign expired = run && (limit != '0) && (nxt == {1'b0, limit});

    // Count running cycles; restart whenever cleared.
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt <= '0;
        else if (clear)  cnt <= '0;
        else if (run)    cnt <= nxt[CW-1:0];
    end
endmodule

// File: rtl/hold_fsm.sv
// Request/grant state machine. grant_ok is already synchronized.
// Every exit from ownership passes through a yield state that waits for the
// engine's cycle to end; a new request needs the grant seen low first.
module hold_fsm
    import bht_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       want_bus,
    input  logic       cycle_busy,
    input  logic       grant_ok,
    input  logic       on_expired,
    input  logic       off_expired,
    input  logic       off_enabled,
    output bus_state_t state,
    output logic       rel_by_timer,
    output logic       hold_req,
    output logic       owns_bus,
    output logic       must_yield
);
    bus_state_t nxt;
    logic       nxt_thr;

    // Next-state and release-reason decision.
    always_comb begin
        nxt     = state;
        nxt_thr = rel_by_timer;
        case (state)
            ST_IDLE:    if (want_bus) nxt = ST_REQ;
            ST_REQ: begin
                if (grant_ok) nxt = ST_OWN;
                else if (!want_bus) begin
                    nxt     = ST_WAITLOW;
                    nxt_thr = 1'b0;
                end
            end
            ST_OWN: begin
                if (!grant_ok) begin
                    nxt     = ST_YIELD;
                    nxt_thr = 1'b0;
                end else if (on_expired) begin
                    nxt     = ST_YIELD;
                    nxt_thr = 1'b1;
                end else if (!want_bus) begin
                    nxt     = ST_YIELD;
                    nxt_thr = 1'b0;
                end
            end
            ST_YIELD:   if (!cycle_busy) nxt = ST_WAITLOW;
            ST_WAITLOW: if (!grant_ok)
                            nxt = (rel_by_timer && off_enabled) ? ST_BACKOFF : ST_IDLE;
            ST_BACKOFF: if (off_expired) nxt = ST_IDLE;
            default:    nxt = ST_IDLE;
        endcase
    end

    // State and release-reason registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state        <= ST_IDLE;
            rel_by_timer <= 1'b0;
        end else begin
            state        <= nxt;
            rel_by_timer <= nxt_thr;
        end
    end

    assign hold_req   = (state == ST_REQ) || (state == ST_OWN) || (state == ST_YIELD);
    assign owns_bus   = (state == ST_OWN) || (state == ST_YIELD);
    assign must_yield = (state == ST_YIELD);
endmodule

// File: rtl/bus_hold_requester.sv
// Bus-master requester: hold/grant handshake plus on-time and off-time
// throttling. Assumes on_limit, off_limit and ext_mode change only while
// the block is not requesting; cycle_busy is low whenever no cycle runs.
module bus_hold_requester
    import bht_pkg::*;
#(
    parameter int CW        = 16,
    parameter int SYNC_STGS = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          want_bus,
    input  logic          cycle_busy,
    input  logic          grant_async,
    input  logic          ext_trig,
    input  logic          ext_mode,
    input  logic [CW-1:0] on_limit,
    input  logic [CW-1:0] off_limit,
    output logic          hold_req,
    output logic          owns_bus,
    output logic          must_yield
);
    bus_state_t state;
    logic       grant_sync;
    logic       rel_by_timer;
    logic       armed;
    logic       on_run;
    logic       on_expired;
    logic       off_expired;
    logic       in_own;
    logic       in_backoff;

    assign in_own     = (state == ST_OWN);
    assign in_backoff = (state == ST_BACKOFF);
    assign on_run     = in_own && (!ext_mode || armed || ext_trig);

    grant_synchronizer #(.STAGES(SYNC_STGS)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (grant_async),
        .sync_out (grant_sync)
    );

    // Remember an external trigger for the rest of the current tenure.
    always_ff @(posedge clk) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= in_own && (armed || ext_trig);
    end

    tenure_timer #(.CW(CW)) u_on_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (!in_own),
        .run     (on_run),
        .limit   (on_limit),
        .expired (on_expired)
    );

    tenure_timer #(.CW(CW)) u_off_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (!in_backoff),
        .run     (in_backoff),
        .limit   (off_limit),
        .expired (off_expired)
    );

    hold_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .want_bus     (want_bus),
        .cycle_busy   (cycle_busy),
        .grant_ok     (grant_sync),
        .on_expired   (on_expired),
        .off_expired  (off_expired),
        .off_enabled  (off_limit != '0),
        .state        (state),
        .rel_by_timer (rel_by_timer),
        .hold_req     (hold_req),
        .owns_bus     (owns_bus),
        .must_yield   (must_yield)
    );
endmodule

// File: rtl/bus_hold_requester_chk.sv
// Property checker for bus_hold_requester, attached by bind below.
module bus_hold_requester_chk #(
    parameter int CW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          grant_async,
    input logic          grant_sync,
    input logic          cycle_busy,
    input logic          ext_mode,
    input logic [CW-1:0] on_limit,
    input logic [CW-1:0] off_limit,
    input logic          rel_by_timer,
    input logic          hold_req,
    input logic          owns_bus,
    input logic          must_yield
);
    logic [CW:0] low_run;
    logic [CW:0] own_run;

    // Length of the current run of cycles without a request (saturating).
    always_ff @(posedge clk) begin
        if (!rst_n || hold_req)  low_run <= '0;
        else if (low_run != '1)  low_run <= low_run + 1'b1;
    end

    // Length of the current run of unrestricted ownership.
    always_ff @(posedge clk) begin
        if (!rst_n || !(owns_bus && !must_yield)) own_run <= '0;
        else if (own_run != '1)                   own_run <= own_run + 1'b1;
    end

    p_own_needs_req_r11: assert property (@(posedge clk) disable iff (!rst_n)
        owns_bus |-> hold_req);

    p_yield_needs_own_r11: assert property (@(posedge clk) disable iff (!rst_n)
        must_yield |-> owns_bus);

    p_own_after_sync_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(owns_bus) |-> $past(grant_async, 2));

    p_grant_loss_yield_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (owns_bus && !must_yield && !grant_sync) |=> must_yield);

    p_bounded_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (must_yield && !cycle_busy) |=> !hold_req);

    p_tenure_limit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (owns_bus && !must_yield && !ext_mode && on_limit != '0)
            |-> (own_run < {1'b0, on_limit}));

    p_off_time_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(hold_req) && rel_by_timer) |-> (low_run >= {1'b0, off_limit}));
endmodule

bind bus_hold_requester bus_hold_requester_chk #(.CW(CW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .grant_async  (grant_async),
    .grant_sync   (grant_sync),
    .cycle_busy   (cycle_busy),
    .ext_mode     (ext_mode),
    .on_limit     (on_limit),
    .off_limit    (off_limit),
    .rel_by_timer (rel_by_timer),
    .hold_req     (hold_req),
    .owns_bus     (owns_bus),
    .must_yield   (must_yield)
);

// File: tb/sim_bus_hold_requester.sv
`timescale 1ns/1ps
module sim_bus_hold_requester;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        want_bus = 1'b0;
    logic        cycle_busy = 1'b0;
    logic        ext_trig = 1'b0;
    logic        ext_mode = 1'b0;
    logic [15:0] on_limit = 16'd0;
    logic [15:0] off_limit = 16'd0;
    logic        auto_grant = 1'b1;
    logic        auto_val = 1'b0;
    logic        man_val = 1'b1;
    logic        grant_async;
    logic        hold_req, owns_bus, must_yield;

    int checks = 0;
    int fails = 0;
    int viol11 = 0;
    bit done = 1'b0;
    string cur = "R1";

    assign grant_async = auto_grant ? auto_val : man_val;

    always #2.5 clk = ~clk;

    bus_hold_requester u0 (
        .clk(clk), .rst_n(rst_n), .want_bus(want_bus), .cycle_busy(cycle_busy),
        .grant_async(grant_async), .ext_trig(ext_trig), .ext_mode(ext_mode),
        .on_limit(on_limit), .off_limit(off_limit),
        .hold_req(hold_req), .owns_bus(owns_bus), .must_yield(must_yield)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Behavioural reference: phase 0 idle, 1 asking, 2 holding, 3 leaving,
    // 4 awaiting grant low, 5 resting.
    int ph = 0, on_el = 0, off_el = 0;
    bit q1 = 0, q2 = 0, m_arm = 0, m_thr = 0;
    always @(posedge clk) begin
        int nph;
        bit gs, go;
        if (!rst_n) begin
            ph = 0; on_el = 0; off_el = 0; q1 = 0; q2 = 0; m_arm = 0; m_thr = 0;
        end else begin
            gs  = q2;
            nph = ph;
            go  = !ext_mode || m_arm || ext_trig;
            if (ph == 0) begin
                if (want_bus) nph = 1;
            end else if (ph == 1) begin
                if (gs) nph = 2;
                else if (!want_bus) begin nph = 4; m_thr = 0; end
            end else if (ph == 2) begin
                if (!gs) begin nph = 3; m_thr = 0; end
                else if (go && on_limit != 0 && on_el + 1 == int'(on_limit)) begin nph = 3; m_thr = 1; end
                else if (!want_bus) begin nph = 3; m_thr = 0; end
            end else if (ph == 3) begin
                if (!cycle_busy) nph = 4;
            end else if (ph == 4) begin
                if (!gs) nph = (m_thr && off_limit != 0) ? 5 : 0;
            end else begin
                if (off_el + 1 == int'(off_limit)) nph = 0;
            end
            if (ph == 2) begin if (go) on_el++; end else on_el = 0;
            m_arm = (ph == 2) && (m_arm || ext_trig);
            if (ph == 5) off_el++; else off_el = 0;
            q2 = q1;
            q1 = grant_async;
            ph = nph;
        end
    end

    // Per-cycle comparison and host model that grants what is requested.
    always @(negedge clk) begin
        int exp_v, act_v;
        if (rst_n) begin
            exp_v = {29'd0, (ph >= 1 && ph <= 3), (ph == 2 || ph == 3), (ph == 3)};
            act_v = {29'd0, hold_req, owns_bus, must_yield};
            chk(exp_v == act_v, cur, "outputs {req,own,yield} vs model", act_v, exp_v);
            if ((owns_bus && !hold_req) || (must_yield && !owns_bus)) viol11++;
        end
        auto_val <= hold_req;
    end

    task automatic wait_own();
        for (int g = 0; g < 60 && !owns_bus; g++) @(negedge clk);
    endtask

    task automatic idle_out();
        want_bus = 1'b0;
        repeat (12) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        int n;
        repeat (4) @(negedge clk);
        cur = "R1";
        chk({hold_req, owns_bus, must_yield} == 3'b000, "R1", "outputs in reset",
            {hold_req, owns_bus, must_yield}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk({hold_req, owns_bus, must_yield} == 3'b000, "R1", "outputs after reset",
            {hold_req, owns_bus, must_yield}, 0);

        // R3 then R2: request and synchronized grant latency.
        cur = "R3";
        want_bus = 1'b1;
        @(negedge clk);
        chk(hold_req == 1'b1, "R3", "hold_req one edge after want", hold_req, 1);
        cur = "R2";
        @(negedge clk);
        chk(owns_bus == 1'b0, "R2", "owns_bus 1 edge after grant", owns_bus, 0);
        @(negedge clk);
        chk(owns_bus == 1'b0, "R2", "owns_bus 2 edges after grant", owns_bus, 0);
        @(negedge clk);
        chk(owns_bus == 1'b1, "R2", "owns_bus 3 edges after grant", owns_bus, 1);
        repeat (10) @(negedge clk);

        // R4: voluntary release, request drops while grant is still high.
        cur = "R4";
        want_bus = 1'b0;
        @(negedge clk);
        chk(must_yield == 1'b1, "R4", "yield after want low", must_yield, 1);
        @(negedge clk);
        chk(!hold_req && grant_async, "R4", "req low with grant high",
            {hold_req, grant_async}, 1);
        repeat (10) @(negedge clk);

        // R5: host pulls the grant during a busy cycle.
        cur = "R5";
        cycle_busy = 1'b1;
        want_bus = 1'b1;
        wait_own();
        repeat (3) @(negedge clk);
        man_val = 1'b0;
        auto_grant = 1'b0;
        repeat (2) @(negedge clk);
        chk(must_yield == 1'b0, "R5", "no yield before sync", must_yield, 0);
        @(negedge clk);
        chk(must_yield && hold_req, "R5", "yield with req held", {must_yield, hold_req}, 3);
        repeat (4) @(negedge clk);
        chk(hold_req == 1'b1, "R5", "req held while busy", hold_req, 1);
        cycle_busy = 1'b0;
        @(negedge clk);
        chk(hold_req == 1'b0, "R5", "req dropped when idle", hold_req, 0);
        want_bus = 1'b0;
        repeat (10) @(negedge clk);
        auto_grant = 1'b1;
        man_val = 1'b1;
        repeat (4) @(negedge clk);

        // R6: grant stuck high after release blocks a new request.
        cur = "R6";
        want_bus = 1'b1;
        wait_own();
        repeat (3) @(negedge clk);
        man_val = 1'b1;
        auto_grant = 1'b0;
        want_bus = 1'b0;
        repeat (2) @(negedge clk);
        want_bus = 1'b1;
        n = 0;
        repeat (8) begin @(negedge clk); if (hold_req) n++; end
        chk(n == 0, "R6", "request cycles while grant high", n, 0);
        man_val = 1'b0;
        n = 0;
        do begin @(negedge clk); n++; end while (!hold_req && n < 30);
        chk(n == 4, "R6", "cycles to re-request after grant low", n, 4);
        auto_grant = 1'b1;
        idle_out();

        // R7 and R10: internal trigger with both limits.
        cur = "R7";
        on_limit = 16'd8;
        off_limit = 16'd5;
        want_bus = 1'b1;
        wait_own();
        n = 0;
        while (owns_bus && !must_yield && n < 100) begin n++; @(negedge clk); end
        chk(n == 8, "R7", "tenure length", n, 8);
        cur = "R10";
        @(negedge clk);
        n = 0;
        while (!hold_req && n < 100) begin n++; @(negedge clk); end
        chk(n == 9, "R10", "low gap with off-time 5", n, 9);
        idle_out();

        // R10: off-time zero gives no extra gap.
        on_limit = 16'd4;
        off_limit = 16'd0;
        want_bus = 1'b1;
        wait_own();
        while (!must_yield) @(negedge clk);
        @(negedge clk);
        n = 0;
        while (!hold_req && n < 100) begin n++; @(negedge clk); end
        chk(n == 4, "R10", "low gap with off-time 0", n, 4);
        idle_out();

        // R8: zero on-time limit never expires.
        cur = "R8";
        on_limit = 16'd0;
        want_bus = 1'b1;
        wait_own();
        n = 0;
        repeat (40) begin @(negedge clk); if (must_yield) n++; end
        chk(n == 0, "R8", "yield cycles with limit off", n, 0);
        idle_out();

        // R9: external trigger starts the on-time count.
        cur = "R9";
        ext_mode = 1'b1;
        on_limit = 16'd6;
        want_bus = 1'b1;
        wait_own();
        n = 0;
        repeat (20) begin @(negedge clk); if (must_yield) n++; end
        chk(n == 0, "R9", "yield cycles before trigger", n, 0);
        ext_trig = 1'b1;
        n = 0;
        do begin
            @(negedge clk);
            n++;
            if (n == 1) ext_trig = 1'b0;
        end while (!must_yield && n < 50);
        chk(n == 6, "R9", "cycles from trigger to yield", n, 6);
        idle_out();
        ext_mode = 1'b0;

        cur = "R11";
        chk(viol11 == 0, "R11", "output ordering violations", viol11, 0);
        done = 1'b1;
        finish_run();
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL %s watchdog: actual hung expected finished", cur);
            finish_run();
        end
    end
endmodule